// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog built around a down-counter that advances only on a slow time-base strobe. Software programs a period value and sets an enable bit. The counter then steps down one count per strobe. When it is at zero, the next strobe is an expiry: the counter reloads the programmed value and a sticky interrupt flag is set. Software shows that it is alive by clearing that flag.

If a second expiry arrives while the flag from the first one is still set, the block concludes that software has stopped servicing it. It then issues a one-cycle reset request for the rest of the system and returns itself to its idle state. A small register port lets software set the period, toggle the enable bit, clear the flag and read back the live count and the flag.

Top module: `wdog_twostage`

## Requirements
- R1: After a synchronous reset, `irq` and `rst_req` are 0, the enable bit is 0, and both the period register and the counter hold `RESET_LOAD` (all ones by default).
- R2: The register port decodes `addr` as follows. Address 0 is the period, read and write. Address 1 is control, where bit 0 is the enable. At address 2, reading returns the pending flag in bit 0, and writing with bit 0 set clears the flag. Address 3 returns the live count and ignores writes. Reads are combinational, and unused bits read 0.
- R3: While enabled, a tick with a nonzero count lowers the count by one. A tick at count zero is an expiry, and it reloads the period value on that same edge. With period value L, expiries are therefore L+1 ticks apart.
- R4: An expiry while no interrupt is pending sets `irq` at that clock edge.
- R5: `irq` stays set until a clear write. A clear issued in the same cycle as an expiry that sets the flag has no effect.
- R6: An expiry while `irq` is already set raises `rst_req` for exactly one cycle. A clear written in that same cycle does not prevent it.
- R7: In the cycle where `rst_req` is high, the enable bit is 0, `irq` is 0 and the count equals the period value. The period value is kept.
- R8: While the enable bit is 0, ticks leave the count unchanged, and neither `irq` nor `rst_req` can be raised.
- R9: A write to the period register loads the counter with the written value at that edge. The write overrides a tick in the same cycle, and that cycle produces no expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe from the slow time base |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational on `addr` |
| irq | output | 1 | Sticky expiry interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the assertions check the following local rules:
- a decrement moves the count by exactly one step;
- the count holds while the block is disabled;
- a period write lands in the counter;
- the flag is sticky;
- a reset request is only one cycle long, always follows a pending flag, and leaves the block idle.

The end-to-end behaviours can only be shown by the bench's scenarios: the exact number of ticks between expiries for each period value, the race between a clear and an expiry, and the two-expiry path to a reset request. The bench sweeps the small period values and derives each expected interval as period plus one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      WD_PERIOD = 2'd0,
      WD_CTRL   = 2'd1,
      WD_STAT   = 2'd2,
      WD_COUNT  = 2'd3
   } wd_reg_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int              CNT_W      = 32,
   parameter int              DATA_W     = 32,
   parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bite,
   input  logic [CNT_W-1:0]  count,
   input  logic              irq,
   output logic [CNT_W-1:0]  load,
   output logic              en,
   output logic              load_wr,
   output logic              clr_wr,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD_W = DATA_W - CNT_W;

   logic             ctrl_wr;
   logic [DATA_W-1:0] load_ext;
   logic [DATA_W-1:0] count_ext;

   assign load_wr = wr_en && (addr == WD_PERIOD);
   assign ctrl_wr = wr_en && (addr == WD_CTRL);
   assign clr_wr  = wr_en && (addr == WD_STAT) && wdata[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         load <= RESET_LOAD;
      end else if (load_wr) begin
         load <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || bite) begin
         en <= 1'b0;
      end else if (ctrl_wr) begin
         en <= wdata[0];
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign load_ext  = {{PAD_W{1'b0}}, load};
         assign count_ext = {{PAD_W{1'b0}}, count};
      end else begin : g_nopad
         assign load_ext  = load;
         assign count_ext = count;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (wd_reg_e'(addr))
         WD_PERIOD: rdata = load_ext;
         WD_CTRL:   rdata[0] = en;
         WD_STAT:   rdata[0] = irq;
         WD_COUNT:  rdata = count_ext;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int              CNT_W      = 32,
   parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             tick,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] wr_val,
   input  logic [CNT_W-1:0] load,
   output logic [CNT_W-1:0] count,
   output logic             expiry
);
   logic at_zero;
   logic step;

   assign at_zero = (count == '0);
   assign step    = en && tick && !load_wr;
   assign expiry  = step && at_zero;

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= RESET_LOAD;
      end else if (load_wr) begin
         count <= wr_val;
      end else if (step) begin
         count <= at_zero ? load : count - 1'b1;
      end
   end
endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm (
   input  logic clk,
   input  logic rst,
   input  logic expiry,
   input  logic clr_wr,
   output logic bite,
   output logic irq,
   output logic rst_req
);
   assign bite = expiry && irq;

   always_ff @(posedge clk) begin
      if (rst || bite) begin
         irq <= 1'b0;
      end else if (expiry) begin
         irq <= 1'b1;
      end else if (clr_wr) begin
         irq <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rst_req <= 1'b0;
      end else begin
         rst_req <= bite;
      end
   end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
   import wdog_pkg::*;
#(
   parameter int              CNT_W      = 32,
   parameter int              DATA_W     = 32,
   parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              rst_req
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         initial $fatal(1, "wdog_twostage: CNT_W must be at least 2");
      end
      if (DATA_W < CNT_W) begin : g_bad_data
         initial $fatal(1, "wdog_twostage: DATA_W must cover CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] count_q;
   logic             en_q;
   logic             load_wr;
   logic             clr_wr;
   logic             expiry;
   logic             bite;

   wdog_regs #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .RESET_LOAD(RESET_LOAD)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .bite(bite), .count(count_q), .irq(irq),
      .load(load_q), .en(en_q), .load_wr(load_wr), .clr_wr(clr_wr),
      .rdata(rdata)
   );

   wdog_counter #(
      .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)
   ) u_cnt (
      .clk(clk), .rst(rst), .en(en_q), .tick(tick), .load_wr(load_wr),
      .wr_val(wdata[CNT_W-1:0]), .load(load_q),
      .count(count_q), .expiry(expiry)
   );

   wdog_alarm u_alarm (
      .clk(clk), .rst(rst), .expiry(expiry), .clr_wr(clr_wr),
      .bite(bite), .irq(irq), .rst_req(rst_req)
   );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic [DATA_W-1:0] wdata,
   input logic              irq,
   input logic              rst_req,
   input logic              en,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  load,
   input logic              load_wr,
   input logic              clr_wr
);
   AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
      (en && tick && !load_wr && count != '0) |=> (count == $past(count) - 1'b1)); // R3
   AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
      (en && tick && !load_wr && count == '0 && !irq) |=> irq); // R4
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
      (irq && !clr_wr) |=> (irq || rst_req)); // R5
   AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
      rst_req |=> !rst_req); // R6
   AST_RST_AFTER_PENDING: assert property (@(posedge clk) disable iff (rst)
      rst_req |-> $past(irq)); // R6
   AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
      rst_req |-> (!irq && !en && count == load)); // R7
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
      (!en && !load_wr) |=> (count == $past(count))); // R8
   AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!rst_req && !$rose(irq))); // R8
   AST_PERIOD_WR: assert property (@(posedge clk) disable iff (rst)
      load_wr |=> (count == $past(wdata[CNT_W-1:0]))); // R9
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .wdata(wdata), .irq(irq),
   .rst_req(rst_req), .en(en_q), .count(count_q), .load(load_q),
   .load_wr(load_wr), .clr_wr(clr_wr)
);

// File: tb/tb_wdog_twostage.sv
`timescale 1ns/1ps
module tb_wdog_twostage;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic        rst_req;

   int n_chk = 0;
   int n_fail = 0;
   int rst_seen = 0;

   always #2.5 clk = ~clk;

   wdog_twostage dut (
      .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         if (rst_req) rst_seen++;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      cyc(1);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   task automatic run_until_irq(output int n);
      tick = 1'b1; n = 0;
      while (!irq && n < 200) begin
         cyc(1);
         n++;
      end
      tick = 1'b0;
   endtask

   initial begin
      #500000;
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n;
      int m;
      int r0;
      cyc(3);
      rst = 1'b0;
      cyc(1);
      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      check("R1 rst_req", {31'd0, rst_req}, 32'd0);
      rd(2'd1, v); check("R1 enable", v, 32'd0);
      rd(2'd0, v); check("R1 period", v, 32'hFFFF_FFFF);
      rd(2'd3, v); check("R1 count", v, 32'hFFFF_FFFF);
      rd(2'd2, v); check("R1 status", v, 32'd0);

      // R2 decode: control reads only bit 0, count ignores writes
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); check("R2 ctrl bits", v, 32'd1);
      wr(2'd1, 32'd0);
      wr(2'd3, 32'd5);
      rd(2'd3, v); check("R2 count write ignored", v, 32'hFFFF_FFFF);

      // R3/R4/R5 sweep over small periods
      for (int L = 0; L <= 6; L++) begin
         wr(2'd0, L);
         wr(2'd1, 32'd1);
         run_until_irq(n);
         check("R3 interval", n, L + 1);
         rd(2'd2, v); check("R4 status set", v, 32'd1);
         rd(2'd3, v); check("R3 reload", v, L);
         if (L == 3) begin
            cyc(5);
            check("R5 sticky", {31'd0, irq}, 32'd1);
         end
         wr(2'd2, 32'd1);
         check("R5 clear", {31'd0, irq}, 32'd0);
         wr(2'd1, 32'd0);
      end
      check("R6 no reset in sweep", rst_seen, 0);

      // R6/R7 second expiry without service
      wr(2'd0, 32'd3);
      wr(2'd1, 32'd1);
      run_until_irq(n);
      check("R6 first interval", n, 4);
      tick = 1'b1; m = 0; r0 = rst_seen;
      while (rst_seen == r0 && m < 200) begin
         cyc(1);
         m++;
      end
      tick = 1'b0;
      check("R6 reset after second expiry", m, 4);
      check("R6 rst_req high", {31'd0, rst_req}, 32'd1);
      check("R7 irq low", {31'd0, irq}, 32'd0);
      rd(2'd1, v); check("R7 disabled", v, 32'd0);
      rd(2'd3, v); check("R7 count", v, 32'd3);
      rd(2'd0, v); check("R7 period kept", v, 32'd3);
      cyc(1);
      check("R6 single cycle", {31'd0, rst_req}, 32'd0);

      // R5 clear racing an expiry that sets the flag
      wr(2'd0, 32'd2);
      wr(2'd1, 32'd1);
      tick = 1'b1;
      cyc(2);
      wr(2'd2, 32'd1);
      tick = 1'b0;
      check("R5 set beats clear", {31'd0, irq}, 32'd1);
      // R6 clear racing the second expiry does not save it
      tick = 1'b1;
      cyc(2);
      r0 = rst_seen;
      wr(2'd2, 32'd1);
      tick = 1'b0;
      check("R6 clear too late", {31'd0, rst_req}, 32'd1);
      cyc(1);

      // R6 timely service prevents reset
      r0 = rst_seen;
      wr(2'd1, 32'd1);
      run_until_irq(n);
      check("R3 interval L2", n, 3);
      wr(2'd2, 32'd1);
      run_until_irq(n);
      check("R3 next interval", n, 3);
      check("R6 serviced no reset", rst_seen - r0, 0);
      wr(2'd2, 32'd1);
      wr(2'd1, 32'd0);

      // R8 disabled hold
      wr(2'd0, 32'd5);
      wr(2'd1, 32'd1);
      tick = 1'b1; cyc(2); tick = 1'b0;
      rd(2'd3, v); check("R3 two ticks", v, 32'd3);
      wr(2'd1, 32'd0);
      tick = 1'b1; cyc(10); tick = 1'b0;
      rd(2'd3, v); check("R8 hold", v, 32'd3);
      wr(2'd0, 32'd1);
      rd(2'd3, v); check("R9 write while off", v, 32'd1);
      wr(2'd1, 32'd1);
      tick = 1'b1; cyc(1); tick = 1'b0;
      wr(2'd1, 32'd0);
      r0 = rst_seen;
      tick = 1'b1; cyc(6); tick = 1'b0;
      check("R8 no irq at zero", {31'd0, irq}, 32'd0);
      check("R8 no reset", rst_seen - r0, 0);
      rd(2'd3, v); check("R8 zero held", v, 32'd0);

      // R9 period write overrides tick and restarts
      wr(2'd0, 32'd10);
      wr(2'd1, 32'd1);
      tick = 1'b1; cyc(4);
      wr(2'd0, 32'd7);
      tick = 1'b0;
      rd(2'd3, v); check("R9 override tick", v, 32'd7);
      run_until_irq(n);
      check("R9 new interval", n, 8);
      wr(2'd2, 32'd1);
      tick = 1'b1; cyc(7);
      wr(2'd0, 32'd4);
      tick = 1'b0;
      check("R9 no expiry on write", {31'd0, irq}, 32'd0);
      rd(2'd3, v); check("R9 count", v, 32'd4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule